// File: doc/BRIEF.md
# Legacy Parallel Port Register Front End

This block sits between a host register bus and the pins of a PC-style parallel port. The host addresses it by block and offset. The lower block holds the data, status and control registers. The upper block holds the mode register, whose mode field is exported to a separate transfer engine. The block drives the eight data lines and their output enable, and the four control lines. It reads back the five peripheral status lines.

The port has two data-line behaviours. In output-only mode the data lines always carry the data register. In bidirectional mode a control bit releases the lines, and a data-register read then returns the levels seen on the pins. An acknowledge-edge interrupt is also provided. It is armed by a control bit, set by a rising edge on the synchronized acknowledge input, and held until the host reads the status register.

Read data is combinational while an access is presented. All register updates and the read side effect take place at the clock edge that ends the access.

Top module: `lpt_port_regs`

## Requirements
- R1: After synchronous reset the port is in output-only mode, with the data register cleared and the data lines driven. All control bits are cleared, so stb_n=1, afd_n=1, init_n=0 and slin_n=1. irq_n=1.
- R2: Lower offset 0 is the data register, lower offset 1 the status register and lower offset 2 the control register. Upper offset 2 is the mode register. Every other offset in either block reads 0x00, and writes to those offsets change no register.
- R3: In output-only mode (mode 3'b000), pd_oe is 1 and pd_out equals the data register for any control value. A data-register read returns the last value written.
- R4: In bidirectional mode (mode 3'b001), control bit 5 set gives pd_oe=0, and a data-register read returns pd_in. Control bit 5 clear gives pd_oe=1 with pd_out equal to the data register.
- R5: Control bit 0 drives stb_n inverted, bit 1 drives afd_n inverted, bit 2 drives init_n uninverted and bit 3 drives slin_n inverted. A control read returns bits 5:0 as written, with bits 7:6 reading 0.
- R6: A status read returns busy, ack_n, pe, slct and err_n in bits 7 to 3, the interrupt flag in bit 2, and 0 in bits 1:0.
- R7: While control bit 4 is set, a rising edge on ack_n, seen after a two-stage synchronizer, sets the interrupt flag and drives irq_n low.
- R8: A rising edge of ack_n while control bit 4 is clear, and any falling edge, leave the flag clear. Setting bit 4 afterwards does not set the flag retroactively.
- R9: A status read returns the flag as 1. The flag clears at the end of that read, so irq_n is 1 afterwards and the next status read shows bit 2 as 0.
- R10: The mode field is bits 7:5 of the mode register. Writes of 3'b000, 3'b001 or 3'b100 (the last selects the transfer engine's mode) take effect and are exported on mode. Writes of any other value leave the mode unchanged. A read returns the mode in bits 7:5, with 0 elsewhere.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Host access presented this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_upper | input | 1 | Selects the upper register block |
| acc_off | input | 3 | Register offset within the block |
| acc_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid while a read is presented |
| pd_out | output | 8 | Data lines, output value |
| pd_oe | output | 1 | Data line output enable |
| pd_in | input | 8 | Data lines, sampled pin levels |
| stb_n | output | 1 | Strobe, active low |
| afd_n | output | 1 | Auto feed, active low |
| init_n | output | 1 | Initialize, active low |
| slin_n | output | 1 | Select in, active low |
| busy | input | 1 | Peripheral busy |
| ack_n | input | 1 | Peripheral acknowledge, active low |
| pe | input | 1 | Paper end |
| slct | input | 1 | Peripheral selected |
| err_n | input | 1 | Peripheral error, active low |
| irq_n | output | 1 | Port interrupt, active low |
| mode | output | 3 | Current mode field |

## Verification
The bench attacks the interrupt corner cases. A falling acknowledge edge must not set the flag, and neither must a rising edge while disabled; a design that looked only at level or ignored the enable would assert irq_n there. Enabling the interrupt after an ignored edge must not produce a late interrupt. The status read must return the flag before clearing it; a design that cleared too early would report bit 2 as 0. The direction bit is checked in both data-line modes, because a design that honoured it in output-only mode would release the lines. All eight mode codes are written, because accepting an unsupported code would leave the exported mode corrupted.

// File: rtl/lpt_pkg.sv
package lpt_pkg;

    localparam int DATA_W = 8;
    localparam int OFF_W  = 3;
    localparam int MODE_W = 3;
    localparam int CTRL_W = 6;

    localparam logic [OFF_W-1:0] OFF_DATA   = 3'd0;
    localparam logic [OFF_W-1:0] OFF_STATUS = 3'd1;
    localparam logic [OFF_W-1:0] OFF_CTRL   = 3'd2;
    localparam logic [OFF_W-1:0] OFF_MODE   = 3'd2;

    localparam int CTRL_STB  = 0;
    localparam int CTRL_AFD  = 1;
    localparam int CTRL_INIT = 2;
    localparam int CTRL_SLIN = 3;
    localparam int CTRL_IEN  = 4;
    localparam int CTRL_DIR  = 5;

    typedef enum logic [MODE_W-1:0] {
        MODE_OUT_ONLY = 3'b000,
        MODE_BIDIR    = 3'b001,
        MODE_XFER     = 3'b100
    } port_mode_e;

    typedef struct packed {
        logic rd_data;
        logic wr_data;
        logic rd_status;
        logic rd_ctrl;
        logic wr_ctrl;
        logic rd_mode;
        logic wr_mode;
    } reg_sel_t;

    typedef struct packed {
        logic busy;
        logic ack_n;
        logic pe;
        logic slct;
        logic err_n;
    } status_pins_t;

    function automatic logic mode_code_ok(input logic [MODE_W-1:0] code);
        return (code == MODE_OUT_ONLY) || (code == MODE_BIDIR) || (code == MODE_XFER);
    endfunction

    function automatic logic [DATA_W-1:0] status_word(input status_pins_t pins,
                                                      input logic flag);
        return {pins, flag, 2'b00};
    endfunction

endpackage

// File: rtl/lpt_host_decode.sv
module lpt_host_decode
    import lpt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_write,
    input  logic             acc_upper,
    input  logic [OFF_W-1:0] acc_off,
    output reg_sel_t         sel
);

    logic rd_req;
    logic wr_req;
    logic lo_hit;
    logic up_hit;

    always_comb begin
        rd_req = acc_valid && !acc_write;
        wr_req = acc_valid &&  acc_write;
        lo_hit = !acc_upper;
        up_hit =  acc_upper;

        sel.rd_data   = rd_req && lo_hit && (acc_off == OFF_DATA);
        sel.wr_data   = wr_req && lo_hit && (acc_off == OFF_DATA);
        sel.rd_status = rd_req && lo_hit && (acc_off == OFF_STATUS);
        sel.rd_ctrl   = rd_req && lo_hit && (acc_off == OFF_CTRL);
        sel.wr_ctrl   = wr_req && lo_hit && (acc_off == OFF_CTRL);
        sel.rd_mode   = rd_req && up_hit && (acc_off == OFF_MODE);
        sel.wr_mode   = wr_req && up_hit && (acc_off == OFF_MODE);
    end

    // R2: one access selects at most one register
    a_r2_one_select: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));

    // R2: no select without a presented access
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (sel == '0));

endmodule

// File: rtl/lpt_ack_edge.sv
module lpt_ack_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ack_n_pin,
    output logic ack_rise
);

    localparam int CHAIN_W = SYNC_STAGES + 1;

    logic [CHAIN_W-1:0] chain;

    generate
        for (genvar i = 0; i < CHAIN_W; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= ack_n_pin;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain[i] <= 1'b1;
                    else     chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign ack_rise = chain[SYNC_STAGES-1] && !chain[SYNC_STAGES];

    // R8: a detected rise is a single-cycle event
    a_r8_rise_pulse: assert property (@(posedge clk) disable iff (rst)
        ack_rise |=> !ack_rise);

endmodule

// File: rtl/lpt_irq_latch.sv
module lpt_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic edge_ev,
    input  logic enable,
    input  logic status_rd,
    output logic flag
);

    logic set_ev;

    assign set_ev = edge_ev && enable;

    always_ff @(posedge clk) begin
        if (rst)            flag <= 1'b0;
        else if (set_ev)    flag <= 1'b1;
        else if (status_rd) flag <= 1'b0;
    end

    // R7: an armed edge sets the flag
    a_r7_armed_edge_sets: assert property (@(posedge clk) disable iff (rst)
        (edge_ev && enable) |=> flag);

    // R8: without an armed edge a clear flag stays clear
    a_r8_no_spurious_set: assert property (@(posedge clk) disable iff (rst)
        (!flag && !(edge_ev && enable)) |=> !flag);

    // R9: a status read with no new edge clears the flag
    a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
        (status_rd && !(edge_ev && enable)) |=> !flag);

    // R9: the flag holds until a status read
    a_r9_hold_until_read: assert property (@(posedge clk) disable iff (rst)
        (flag && !status_rd) |=> flag);

endmodule

// File: rtl/lpt_port_regs.sv
module lpt_port_regs
    import lpt_pkg::*;
#(
    parameter int ACK_SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_upper,
    input  logic [OFF_W-1:0]  acc_off,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] pd_out,
    output logic              pd_oe,
    input  logic [DATA_W-1:0] pd_in,
    output logic              stb_n,
    output logic              afd_n,
    output logic              init_n,
    output logic              slin_n,
    input  logic              busy,
    input  logic              ack_n,
    input  logic              pe,
    input  logic              slct,
    input  logic              err_n,
    output logic              irq_n,
    output logic [MODE_W-1:0] mode
);

    localparam int MODE_LSB = DATA_W - MODE_W;

    reg_sel_t          sel;
    logic [DATA_W-1:0] data_q;
    logic [CTRL_W-1:0] ctrl_q;
    port_mode_e        mode_q;
    logic              ack_rise;
    logic              irq_flag;
    status_pins_t      pins;
    logic [MODE_W-1:0] mode_wr;

    lpt_host_decode u_decode (
        .clk       (clk),
        .rst       (rst),
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_upper (acc_upper),
        .acc_off   (acc_off),
        .sel       (sel)
    );

    lpt_ack_edge #(
        .SYNC_STAGES (ACK_SYNC_STAGES)
    ) u_ack (
        .clk       (clk),
        .rst       (rst),
        .ack_n_pin (ack_n),
        .ack_rise  (ack_rise)
    );

    lpt_irq_latch u_irq (
        .clk       (clk),
        .rst       (rst),
        .edge_ev   (ack_rise),
        .enable    (ctrl_q[CTRL_IEN]),
        .status_rd (sel.rd_status),
        .flag      (irq_flag)
    );

    assign mode_wr = acc_wdata[DATA_W-1:MODE_LSB];

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
            ctrl_q <= '0;
            mode_q <= MODE_OUT_ONLY;
        end else begin
            if (sel.wr_data) data_q <= acc_wdata;
            if (sel.wr_ctrl) ctrl_q <= acc_wdata[CTRL_W-1:0];
            if (sel.wr_mode && mode_code_ok(mode_wr)) mode_q <= port_mode_e'(mode_wr);
        end
    end

    always_comb begin
        pins.busy  = busy;
        pins.ack_n = ack_n;
        pins.pe    = pe;
        pins.slct  = slct;
        pins.err_n = err_n;
    end

    assign pd_oe  = !((mode_q == MODE_BIDIR) && ctrl_q[CTRL_DIR]);
    assign pd_out = data_q;
    assign stb_n  = !ctrl_q[CTRL_STB];
    assign afd_n  = !ctrl_q[CTRL_AFD];
    assign init_n =  ctrl_q[CTRL_INIT];
    assign slin_n = !ctrl_q[CTRL_SLIN];
    assign irq_n  = !irq_flag;
    assign mode   = mode_q;

    always_comb begin
        rd_data = '0;
        if (sel.rd_data)   rd_data = pd_oe ? data_q : pd_in;
        if (sel.rd_status) rd_data = status_word(pins, irq_flag);
        if (sel.rd_ctrl)   rd_data = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
        if (sel.rd_mode)   rd_data = {mode_q, {MODE_LSB{1'b0}}};
    end

    // R1: reset returns the port to output-only mode with cleared registers
    a_r1_reset_state: assert property (@(posedge clk)
        rst |=> (mode == MODE_OUT_ONLY && pd_out == '0 && pd_oe && irq_n));

    // R3: output-only mode never releases the data lines
    a_r3_out_only_drives: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_OUT_ONLY) |-> pd_oe);

    // R10: the exported mode is always one of the accepted codes
    a_r10_mode_legal: assert property (@(posedge clk) disable iff (rst)
        mode_code_ok(mode));

    // R10: a write of an unaccepted code leaves the mode unchanged
    a_r10_bad_code_held: assert property (@(posedge clk) disable iff (rst)
        (sel.wr_mode && !mode_code_ok(mode_wr)) |=> $stable(mode));

    // R2: writes to unmapped offsets leave the data and control registers alone
    a_r2_unmapped_write: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && (acc_off > OFF_CTRL)) |=> ($stable(pd_out) && $stable(stb_n)
                                                         && $stable(init_n) && $stable(mode)));

endmodule

// File: tb/tb_lpt_port_regs.sv
module tb_lpt_port_regs;

    logic       clk = 1'b0;
    logic       rst;
    logic       acc_valid, acc_write, acc_upper;
    logic [2:0] acc_off;
    logic [7:0] acc_wdata;
    logic [7:0] rd_data, pd_out, pd_in;
    logic       pd_oe, stb_n, afd_n, init_n, slin_n;
    logic       busy, ack_n, pe, slct, err_n, irq_n;
    logic [2:0] mode;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    lpt_port_regs dut (
        .clk(clk), .rst(rst),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_upper(acc_upper),
        .acc_off(acc_off), .acc_wdata(acc_wdata), .rd_data(rd_data),
        .pd_out(pd_out), .pd_oe(pd_oe), .pd_in(pd_in),
        .stb_n(stb_n), .afd_n(afd_n), .init_n(init_n), .slin_n(slin_n),
        .busy(busy), .ack_n(ack_n), .pe(pe), .slct(slct), .err_n(err_n),
        .irq_n(irq_n), .mode(mode)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic up, input logic [2:0] off, input logic [7:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 1; acc_upper = up; acc_off = off; acc_wdata = d;
        @(negedge clk);
        acc_valid = 0; acc_write = 0;
        #1;
    endtask

    task automatic rd(input logic up, input logic [2:0] off, output logic [7:0] d);
        @(negedge clk);
        acc_valid = 1; acc_write = 0; acc_upper = up; acc_off = off;
        #1 d = rd_data;
        @(negedge clk);
        acc_valid = 0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [7:0] mode_exp;
        rst = 1; acc_valid = 0; acc_write = 0; acc_upper = 0; acc_off = 0; acc_wdata = 0;
        pd_in = 8'h5A; busy = 0; ack_n = 1; pe = 0; slct = 1; err_n = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        #1;

        // R1 reset state
        chk("R1 pd_out", pd_out, 8'h00);
        chk("R1 pins", {pd_oe, stb_n, afd_n, init_n, slin_n, irq_n}, 8'b0011_1011);
        chk("R1 mode", {5'b0, mode}, 8'h00);

        // R3 data register sweep in output-only mode
        for (int v = 0; v < 256; v++) begin
            wr(0, 3'd0, v[7:0]);
            chk("R3 pd_out", pd_out, v[7:0]);
            rd(0, 3'd0, r);
            chk("R3 readback", r, v[7:0]);
        end

        // R5 control sweep, R3 direction bit ignored in output-only mode
        for (int v = 0; v < 64; v++) begin
            wr(0, 3'd2, {2'b11, v[5:0]});
            chk("R5 pins", {4'b0, stb_n, afd_n, init_n, slin_n},
                {4'b0, ~v[0], ~v[1], v[2], ~v[3]});
            rd(0, 3'd2, r);
            chk("R5 readback", r, {2'b00, v[5:0]});
            chk("R3 oe", {7'b0, pd_oe}, 8'h01);
        end
        wr(0, 3'd2, 8'h00);

        // R2 unmapped offsets read 0 and writes are ignored
        wr(0, 3'd0, 8'hC3);
        for (int o = 0; o < 8; o++) begin
            if (o > 2) begin
                wr(0, o[2:0], 8'hFF);
                rd(0, o[2:0], r);
                chk("R2 lower unmapped", r, 8'h00);
            end
            if (o != 2) begin
                wr(1, o[2:0], 8'hFF);
                rd(1, o[2:0], r);
                chk("R2 upper unmapped", r, 8'h00);
            end
        end
        chk("R2 data kept", pd_out, 8'hC3);
        rd(0, 3'd2, r);
        chk("R2 ctrl kept", r, 8'h00);
        chk("R2 mode kept", {5'b0, mode}, 8'h00);

        // R10 mode code sweep
        mode_exp = 8'h00;
        for (int c = 0; c < 8; c++) begin
            wr(1, 3'd2, {c[2:0], 5'b10101});
            if (c == 0 || c == 1 || c == 4) mode_exp = {c[2:0], 5'b0};
            rd(1, 3'd2, r);
            chk("R10 mode read", r, mode_exp);
            chk("R10 mode port", {5'b0, mode}, {5'b0, mode_exp[7:5]});
        end

        // R4 bidirectional mode
        wr(1, 3'd2, 8'h20);
        wr(0, 3'd0, 8'h3C);
        wr(0, 3'd2, 8'h20);
        chk("R4 released", {7'b0, pd_oe}, 8'h00);
        for (int v = 0; v < 256; v += 37) begin
            pd_in = v[7:0];
            rd(0, 3'd0, r);
            chk("R4 pin read", r, v[7:0]);
        end
        wr(0, 3'd2, 8'h00);
        chk("R4 driven", {7'b0, pd_oe}, 8'h01);
        rd(0, 3'd0, r);
        chk("R4 reg read", r, 8'h3C);
        chk("R4 pd_out", pd_out, 8'h3C);
        wr(1, 3'd2, 8'h00);

        // R6 status sweep with interrupt disabled
        for (int v = 0; v < 32; v++) begin
            {busy, ack_n, pe, slct, err_n} = v[4:0];
            idle(1);
            rd(0, 3'd1, r);
            chk("R6 status", r, {v[4:0], 3'b000});
        end
        ack_n = 1;
        idle(5);

        // R8 disabled rising edge, then late enable
        ack_n = 0; idle(5);
        ack_n = 1; idle(5);
        chk("R8 disabled edge", {7'b0, irq_n}, 8'h01);
        wr(0, 3'd2, 8'h10);
        idle(5);
        chk("R8 late enable", {7'b0, irq_n}, 8'h01);

        // R8 falling edge while enabled
        ack_n = 0; idle(5);
        chk("R8 falling edge", {7'b0, irq_n}, 8'h01);

        // R7 rising edge while enabled
        ack_n = 1; idle(5);
        chk("R7 irq asserted", {7'b0, irq_n}, 8'h00);
        idle(10);
        chk("R9 irq held", {7'b0, irq_n}, 8'h00);

        // R9 read returns flag then clears it
        rd(0, 3'd1, r);
        chk("R9 flag seen", r, {busy, ack_n, pe, slct, err_n, 3'b100});
        chk("R9 irq released", {7'b0, irq_n}, 8'h01);
        rd(0, 3'd1, r);
        chk("R9 flag cleared", r, {busy, ack_n, pe, slct, err_n, 3'b000});

        // R7 a second edge sets again
        ack_n = 0; idle(4);
        ack_n = 1; idle(5);
        chk("R7 second edge", {7'b0, irq_n}, 8'h00);
        rd(0, 3'd1, r);
        chk("R9 second read", r[2:0], 3'b100);

        // R1 reset again from a dirty state
        wr(0, 3'd0, 8'hA5);
        wr(0, 3'd2, 8'h3F);
        wr(1, 3'd2, 8'h80);
        @(negedge clk) rst = 1;
        @(negedge clk) rst = 0;
        #1;
        chk("R1 re-reset data", pd_out, 8'h00);
        chk("R1 re-reset pins", {pd_oe, stb_n, afd_n, init_n, slin_n, irq_n}, 8'b0011_1011);
        chk("R1 re-reset mode", {5'b0, mode}, 8'h00);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule